// File: doc/BRIEF.md
# Torus Dimension-Order Route and Virtual-Channel Selector

This unit sits in one switch of a two-dimensional torus with K nodes along each axis. The neighbour links in each dimension wrap around from position K-1 back to position 0. When a head flit arrives, the switch presents the flit's target coordinates to the unit. It also presents its own coordinates, the direction in which the flit travelled on its last hop, and the virtual channel that hop used. The unit settles the X dimension first and then Y. It always takes a shortest path, so the result depends only on where the packet is and where it is going.

Plain dimension-order routing can deadlock on a torus, because the wrap links close a ring of channel dependences. To break that ring, the unit moves a packet onto virtual channel 1 at the hop that crosses a wrap link. The packet stays on channel 1 for the rest of that dimension and drops back to channel 0 when it turns into the next dimension or leaves the network.

The unit answers through a registered handshake. An accepted request produces a result one cycle later. That result is held until the requester acknowledges it, and no new request is taken in the meantime.

Top module: `torus_dor_route`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. The result appears with `rsp_valid` set after that same edge.
- R3: While `rsp_valid` is 1 and `rsp_ack` is 0, `rsp_valid`, `rsp_port` and `rsp_vc` stay unchanged and `req_ready` is 0. Any request offered in that time is ignored.
- R4: A rising edge with `rsp_valid` and `rsp_ack` both 1 clears `rsp_valid`, which makes the unit ready again.
- R5: Output port codes are: 0 local, 1 X increasing, 2 X decreasing, 3 Y increasing, 4 Y decreasing. The same codes describe `req_in_dir`. When the target X differs from the switch X, the port is 1 or 2.
- R6: When the X coordinates match and the Y coordinates differ, the port is 3 or 4.
- R7: When both coordinates match, the port is 0 (local) and the virtual channel is 0.
- R8: Let f be (target - own) mod K in the chosen dimension. The increasing direction is taken when 2*f <= K, and the decreasing direction is taken otherwise. An exact half-way tie therefore goes to the increasing direction.
- R9: A hop that crosses a wrap link (increasing from K-1, or decreasing from 0) is given virtual channel 1.
- R10: A hop that does not cross a wrap link gets channel 1 only when the flit arrived on channel 1 travelling in the same dimension as the chosen output. Otherwise it gets channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| my_x | input | CW | X coordinate of this switch |
| my_y | input | CW | Y coordinate of this switch |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Unit can take a request |
| req_dst_x | input | CW | Target X coordinate |
| req_dst_y | input | CW | Target Y coordinate |
| req_in_dir | input | 3 | Travel direction of the arriving hop (R5 codes) |
| req_in_vc | input | 1 | Virtual channel of the arriving hop |
| rsp_valid | output | 1 | Result held |
| rsp_ack | input | 1 | Requester takes the result |
| rsp_port | output | 3 | Chosen output port (R5 codes) |
| rsp_vc | output | 1 | Chosen virtual channel |

CW is clog2(K).

## Verification
The bound checker enforces the handshake on every cycle. It checks that an accepted request yields a result, that the result stays frozen until acknowledged, that an acknowledge releases it, and that ready and valid never overlap. It also checks that the port code stays in range and that an ejecting result always uses channel 0. Whether the chosen direction is the shorter way round, whether half-way ties go the increasing way, and whether the channel changes at the wrap link and resets on a turn all depend on coordinates. Only the bench shows those, by sweeping every switch position, target, arrival direction and arrival channel of a six-node ring and comparing each result with a value it computes arithmetically.

// File: rtl/torus_dor_route.sv
module torus_dor_route #(
  parameter int K = 8,
  localparam int CW = (K > 2) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] my_x,
  input  logic [CW-1:0] my_y,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [CW-1:0] req_dst_x,
  input  logic [CW-1:0] req_dst_y,
  input  logic [2:0]    req_in_dir,
  input  logic          req_in_vc,
  output logic          rsp_valid,
  input  logic          rsp_ack,
  output logic [2:0]    rsp_port,
  output logic          rsp_vc
);

  localparam logic [CW:0]   KW  = K[CW:0];
  localparam logic [CW-1:0] TOP = CW'(K - 1);

  function automatic logic [CW:0] fwd_dist(input logic [CW-1:0] cur, input logic [CW-1:0] dst);
    if (dst >= cur) fwd_dist = {1'b0, dst} - {1'b0, cur};
    else            fwd_dist = {1'b0, dst} + KW - {1'b0, cur};
  endfunction

  logic [CW:0] fx, fy;
  logic        x_neg, y_neg;
  logic [2:0]  nxt_port;
  logic        wrap_hop, same_dim, nxt_vc;

  assign fx    = fwd_dist(my_x, req_dst_x);
  assign fy    = fwd_dist(my_y, req_dst_y);
  assign x_neg = {fx, 1'b0} > {1'b0, KW};
  assign y_neg = {fy, 1'b0} > {1'b0, KW};

  always_comb begin
    if (fx != '0)      nxt_port = x_neg ? 3'd2 : 3'd1;
    else if (fy != '0) nxt_port = y_neg ? 3'd4 : 3'd3;
    else               nxt_port = 3'd0;
  end

  always_comb begin
    case (nxt_port)
      3'd1:    wrap_hop = (my_x == TOP);
      3'd2:    wrap_hop = (my_x == '0);
      3'd3:    wrap_hop = (my_y == TOP);
      3'd4:    wrap_hop = (my_y == '0);
      default: wrap_hop = 1'b0;
    endcase
  end

  assign same_dim = ((nxt_port == 3'd1 || nxt_port == 3'd2) && (req_in_dir == 3'd1 || req_in_dir == 3'd2))
                 || ((nxt_port == 3'd3 || nxt_port == 3'd4) && (req_in_dir == 3'd3 || req_in_dir == 3'd4));
  assign nxt_vc   = (nxt_port != 3'd0) && (wrap_hop || (req_in_vc && same_dim));

  assign req_ready = ~rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= 3'd0;
      rsp_vc    <= 1'b0;
    end else if (rsp_valid) begin
      if (rsp_ack) rsp_valid <= 1'b0;
    end else if (req_valid) begin
      rsp_valid <= 1'b1;
      rsp_port  <= nxt_port;
      rsp_vc    <= nxt_vc;
    end
  end

endmodule

// File: rtl/torus_dor_route_chk.sv
module torus_dor_route_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_ack,
  input logic [2:0] rsp_port,
  input logic       rsp_vc
);

  // R2
  accept_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R3
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_port) && $stable(rsp_vc));

  // R3
  no_ready_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R4
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ack |=> !rsp_valid && req_ready);

  // R5
  port_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_port <= 3'd4);

  // R7
  local_on_vc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_port == 3'd0 |-> !rsp_vc);

endmodule

bind torus_dor_route torus_dor_route_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_port(rsp_port), .rsp_vc(rsp_vc)
);

// File: tb/torus_dor_route_tb_top.sv
`timescale 1ns/1ps
module torus_dor_route_tb_top;
  localparam int K  = 6;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] my_x = '0, my_y = '0, req_dst_x = '0, req_dst_y = '0;
  logic req_valid = 1'b0, req_in_vc = 1'b0, rsp_ack = 1'b0;
  logic [2:0] req_in_dir = 3'd0;
  logic req_ready, rsp_valid, rsp_vc;
  logic [2:0] rsp_port;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  torus_dor_route #(.K(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .my_x(my_x), .my_y(my_y),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_dst_x(req_dst_x), .req_dst_y(req_dst_y),
    .req_in_dir(req_in_dir), .req_in_vc(req_in_vc),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
    .rsp_port(rsp_port), .rsp_vc(rsp_vc)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic int ref_port(input int mx, input int my, input int dx, input int dy);
    int f;
    f = (dx - mx + K) % K;
    if (f != 0) return (2 * f <= K) ? 1 : 2;
    f = (dy - my + K) % K;
    if (f != 0) return (2 * f <= K) ? 3 : 4;
    return 0;
  endfunction

  function automatic int axis(input int p);
    if (p == 1 || p == 2) return 1;
    if (p == 3 || p == 4) return 2;
    return 0;
  endfunction

  task automatic route(input int mx, input int my, input int dx, input int dy, input int idir, input int ivc);
    int p, v, crosses, tie;
    string tag;
    p = ref_port(mx, my, dx, dy);
    crosses = (p == 1 && mx == K-1) || (p == 2 && mx == 0) || (p == 3 && my == K-1) || (p == 4 && my == 0);
    if (p == 0) v = 0;
    else if (crosses) v = 1;
    else v = (ivc == 1 && axis(p) == axis(idir)) ? 1 : 0;
    tie = (p == 1 || p == 2) ? ((dx - mx + K) % K) * 2 == K
        : (p == 3 || p == 4) ? ((dy - my + K) % K) * 2 == K : 0;
    if (p == 0) tag = "R7";
    else if (crosses) tag = "R9";
    else if (ivc == 1) tag = "R10";
    else if (tie) tag = "R8";
    else if (axis(p) == 1) tag = "R5";
    else tag = "R6";
    @(negedge clk);
    my_x = CW'(mx); my_y = CW'(my); req_dst_x = CW'(dx); req_dst_y = CW'(dy);
    req_in_dir = 3'(idir); req_in_vc = ivc[0]; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({"R2 valid ", tag}, int'(rsp_valid), 1);
    check({tag, " port"}, int'(rsp_port), p);
    check({tag, " vc"}, int'(rsp_vc), v);
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    check("R4 ack without result ignored", int'(rsp_valid), 0);

    // R3: hold, ignore a second request, then R4 release
    my_x = 3'd5; my_y = 3'd0; req_dst_x = 3'd1; req_dst_y = 3'd0;
    req_in_dir = 3'd0; req_in_vc = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    my_x = 3'd2; req_dst_x = 3'd2; req_dst_y = 3'd3;
    repeat (3) @(negedge clk);
    check("R3 held valid", int'(rsp_valid), 1);
    check("R3 ready low", int'(req_ready), 0);
    check("R3 held port", int'(rsp_port), 1);
    check("R3 held vc", int'(rsp_vc), 1);
    req_valid = 1'b0;
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    check("R4 released", int'(rsp_valid), 0);
    check("R4 ready", int'(req_ready), 1);
    @(negedge clk);
    check("R4 stays idle", int'(rsp_valid), 0);

    for (int mx = 0; mx < K; mx++)
      for (int my = 0; my < K; my++)
        for (int dx = 0; dx < K; dx++)
          for (int dy = 0; dy < K; dy++)
            for (int idir = 0; idir < 5; idir++)
              for (int ivc = 0; ivc < 2; ivc++)
                route(mx, my, dx, dy, idir, ivc);

    finish_up();
  end
endmodule